// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block runs clocked burst reads out of a 16-bit memory array. A host drives chip enable low and pulses an address strobe. On that clock edge the block captures a start address and an 8-bit configuration word. It then holds a wait indication for a programmable number of cycles. After that it delivers one array word per clock. The burst either streams on without limit or stops after a fixed count of 4, 8 or 16 words. Fixed bursts can wrap inside an aligned block, and they can use an interleaved order. The host ends a burst at any time by raising chip enable, or starts a new one by strobing a new address.

The block also reproduces one timing feature of a continuous linear burst with wrap enabled. When such a burst starts in one of the last three words of a 16-word group, the output pauses once as it moves into the next group. The pause lasts as long as the initial latency. Later group crossings in the same burst do not pause. The array contents are modelled by a fixed function of the address, so every word can be predicted.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is high and in the cycle after reset, `rd_wait` and `rd_valid` are 0 and `rd_data` is 0.
- R2: A rising clock edge with `chip_en_n`=0 and `addr_strobe_n`=0 captures `addr_in` and `cfg_word` and starts a new burst. This also applies during a burst that is already running, and it abandons that burst.
- R3: Configuration bits [6:4] hold a field F, and the initial latency is L = F+1 cycles. After the capture edge, `rd_wait` is 1 for exactly L cycles. The first word of the burst follows in the next cycle.
- R4: The word at address a is (a[15:0]) XOR (a>>16)[15:0] XOR 16'hC3A5. When `rd_valid` is 0, `rd_data` is 0.
- R5: If configuration bits [2:0] are 0 or 4..7, the burst is continuous. It outputs consecutive addresses, one per clock, with no end, and it rolls over at the top of the address space.
- R6: If configuration bits [2:0] are 1, 2 or 3, the burst is fixed at 4, 8 or 16 words. After the last word the block goes idle, with `rd_wait` and `rd_valid` both 0.
- R7: A fixed burst with bit 7 = 1 (linear) and bit 3 = 1 (wrap) wraps inside the aligned block of its length. With bit 3 = 0 the addresses simply increase.
- R8: A fixed burst with bit 7 = 0 (interleaved) uses the address whose low bits are the start offset XOR the word index, inside the aligned block of the burst length.
- R9: A continuous burst with bit 7 = 1 and bit 3 = 1 may start at offset 13, 14 or 15 within a 16-word group. In that case `rd_wait` is 1 for L cycles between the word at offset 15 and the first word of the next group. Start offsets 0..12 cause no pause.
- R10: The R9 pause happens at most once per burst. Later group crossings stream without a gap.
- R11: A rising edge with `chip_en_n`=1 ends any burst. In the next cycle `rd_wait` and `rd_valid` are 0.
- R12: While `out_en_n`=1, `rd_valid` is 0 and `rd_data` is 0. The burst still moves forward one address per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr_strobe_n | input | 1 | Address strobe, active low |
| cfg_word | input | 8 | Burst configuration, captured with the address |
| addr_in | input | ADDR_W | Start word address |
| rd_data | output | 16 | Burst data word |
| rd_valid | output | 1 | rd_data holds a valid word |
| rd_wait | output | 1 | Latency or boundary pause in progress |

## Verification
A wrong address index or wrap mask shows up as a wrong data word in the first cycle it is used, because each array word is a distinct function of its address. A latency counter that is off by one moves the first valid word by one cycle. A stall flag that is not set, or that is not cleared, changes the number of wait cycles within one group crossing. The reference model checks every cycle, so each of these faults is reported within a few clocks of the event that exposes it.

// File: rtl/burst_read_pkg.sv
`timescale 1ns/1ps
package burst_read_pkg;

    localparam int WORD_W     = 16;
    localparam int GROUP_W    = 4;   // 16-word group
    localparam int STALL_FROM = 13;  // first start offset that pauses at the crossing
    localparam logic [WORD_W-1:0] ARRAY_SEED = 16'hC3A5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_DATA,
        ST_STALL
    } brs_state_e;

    // bit 7 linear, bits 6:4 latency field, bit 3 wrap, bits 2:0 length code
    typedef struct packed {
        logic       linear;
        logic [2:0] lat;
        logic       wrap;
        logic [2:0] len;
    } brs_cfg_t;

    function automatic logic is_fixed(input logic [2:0] len);
        return (len == 3'd1) || (len == 3'd2) || (len == 3'd3);
    endfunction

    function automatic int blk_words(input logic [2:0] len);
        return 1 << (int'(len) + 1);
    endfunction

    function automatic logic stall_arm(input brs_cfg_t c, input logic [GROUP_W-1:0] off);
        return c.linear && c.wrap && !is_fixed(c.len) && (off >= GROUP_W'(STALL_FROM));
    endfunction

    function automatic logic [WORD_W-1:0] array_word(input logic [31:0] a);
        return a[15:0] ^ a[31:16] ^ ARRAY_SEED;
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
    import burst_read_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic [AW-1:0] start,
    input  logic [AW-1:0] idx,
    input  logic          linear,
    input  logic          wrap,
    input  logic [2:0]    len,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] lin_sum;
    logic [AW-1:0] mask;

    always_comb begin
        lin_sum = start + idx;
        mask    = AW'(blk_words(len) - 1);
        if (!is_fixed(len)) begin
            addr = lin_sum;
        end else if (!linear) begin
            addr = (start & ~mask) | ((start ^ idx) & mask);
        end else if (wrap) begin
            addr = (start & ~mask) | (lin_sum & mask);
        end else begin
            addr = lin_sum;
        end
    end

endmodule

// File: rtl/burst_read_ctrl.sv
`timescale 1ns/1ps
module burst_read_ctrl
    import burst_read_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chip_en_n,
    input  logic               addr_strobe_n,
    input  brs_cfg_t           cfg_in,
    input  logic [AW-1:0]      addr_in,
    input  logic [GROUP_W-1:0] cur_off,
    output brs_state_e         state,
    output brs_cfg_t           cfg_q,
    output logic [AW-1:0]      start_q,
    output logic [AW-1:0]      idx_q,
    output logic               capture
);

    localparam int CNT_W = $bits(cfg_in.lat);

    logic [CNT_W-1:0] cnt_q;
    logic             stall_pend_q;
    logic             last_word;
    logic             group_end;

    assign capture   = !chip_en_n && !addr_strobe_n;
    assign last_word = is_fixed(cfg_q.len) && (idx_q == AW'(blk_words(cfg_q.len) - 1));
    assign group_end = (cur_off == {GROUP_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            cnt_q        <= '0;
            idx_q        <= '0;
            start_q      <= '0;
            cfg_q        <= '0;
            stall_pend_q <= 1'b0;
        end else if (chip_en_n) begin
            state        <= ST_IDLE;
            stall_pend_q <= 1'b0;
        end else if (capture) begin
            state        <= ST_LAT;
            cnt_q        <= cfg_in.lat;
            idx_q        <= '0;
            start_q      <= addr_in;
            cfg_q        <= cfg_in;
            stall_pend_q <= stall_arm(cfg_in, addr_in[GROUP_W-1:0]);
        end else begin
            case (state)
                ST_LAT, ST_STALL: begin
                    if (cnt_q == '0) state <= ST_DATA;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                ST_DATA: begin
                    if (last_word) begin
                        state <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        if (stall_pend_q && group_end) begin
                            state        <= ST_STALL;
                            cnt_q        <= cfg_q.lat;
                            stall_pend_q <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
module burst_read_seq
    import burst_read_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              addr_strobe_n,
    input  logic [7:0]        cfg_word,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_wait
);

    brs_cfg_t          cfg_in;
    brs_cfg_t          cfg_q;
    brs_state_e        state;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] burst_addr;
    logic              capture;
    logic              in_data;

    assign cfg_in = brs_cfg_t'(cfg_word);

    burst_read_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .chip_en_n     (chip_en_n),
        .addr_strobe_n (addr_strobe_n),
        .cfg_in        (cfg_in),
        .addr_in       (addr_in),
        .cur_off       (burst_addr[GROUP_W-1:0]),
        .state         (state),
        .cfg_q         (cfg_q),
        .start_q       (start_q),
        .idx_q         (idx_q),
        .capture       (capture)
    );

    burst_addr_gen #(.AW(ADDR_W)) u_agen (
        .start  (start_q),
        .idx    (idx_q),
        .linear (cfg_q.linear),
        .wrap   (cfg_q.wrap),
        .len    (cfg_q.len),
        .addr   (burst_addr)
    );

    assign in_data  = (state == ST_DATA);
    assign rd_wait  = (state == ST_LAT) || (state == ST_STALL);
    assign rd_valid = in_data && !out_en_n;
    assign rd_data  = rd_valid ? array_word(32'(burst_addr)) : '0;

endmodule

// File: rtl/burst_read_seq_chk.sv
`timescale 1ns/1ps
module burst_read_seq_chk
    import burst_read_pkg::*;
#(
    parameter int AW = 23
) (
    input logic          clk,
    input logic          rst,
    input logic          chip_en_n,
    input logic          out_en_n,
    input logic          rd_wait,
    input logic          rd_valid,
    input logic          in_data,
    input logic          capture,
    input logic [AW-1:0] burst_addr,
    input brs_cfg_t      cfg_q
);

    int words_seen;

    always_ff @(posedge clk) begin
        if (rst || capture) words_seen <= 0;
        else if (in_data)   words_seen <= words_seen + 1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!rd_wait && !rd_valid));

    p_capture_wait_r3: assert property (@(posedge clk) disable iff (rst)
        capture |=> rd_wait);

    p_linear_step_r5: assert property (@(posedge clk) disable iff (rst)
        (in_data && $past(in_data) && !$past(capture) && !is_fixed(cfg_q.len))
        |-> (burst_addr == $past(burst_addr) + AW'(1)));

    p_fixed_len_r6: assert property (@(posedge clk) disable iff (rst)
        (in_data && is_fixed(cfg_q.len)) |-> (words_seen < blk_words(cfg_q.len)));

    p_ce_ends_r11: assert property (@(posedge clk) disable iff (rst)
        chip_en_n |=> (!rd_wait && !in_data));

    p_oe_gate_r12: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rd_valid);

endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_en_n  (chip_en_n),
    .out_en_n   (out_en_n),
    .rd_wait    (rd_wait),
    .rd_valid   (rd_valid),
    .in_data    (in_data),
    .capture    (capture),
    .burst_addr (burst_addr),
    .cfg_q      (cfg_q)
);

// File: tb/burst_read_seq_bench.sv
`timescale 1ns/1ps
module burst_read_seq_bench;

    localparam int CLK_P  = 10;
    localparam int AW     = 23;
    localparam int AMASK  = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n, oe_n, stb_n;
    logic [7:0]    cfg_v;
    logic [AW-1:0] addr_v;
    logic [15:0]   rd_data;
    logic          rd_valid, rd_wait;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    checking = 0;
    string cur_tag = "R1";
    int    q[$];
    logic [15:0] obs[$];
    int    obs_wait;

    always #(CLK_P/2) clk = ~clk;

    burst_read_seq #(.ADDR_W(AW)) u_burst_read_seq (
        .clk           (clk),
        .rst           (rst),
        .chip_en_n     (ce_n),
        .out_en_n      (oe_n),
        .addr_strobe_n (stb_n),
        .cfg_word      (cfg_v),
        .addr_in       (addr_v),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid),
        .rd_wait       (rd_wait)
    );

    function automatic logic [15:0] word_of(input int a);
        return 16'(a) ^ 16'(a >> 16) ^ 16'hC3A5;
    endfunction

    // expected entries: -1 wait cycle, >=0 address of a data cycle, empty queue = idle
    task automatic build_q(input int cv, input int a);
        int lat_c, ln, n, base, a2;
        bit lin, wr, armed;
        q.delete();
        lat_c = ((cv >> 4) & 7) + 1;
        lin   = cv[7];
        wr    = cv[3];
        ln    = cv & 7;
        for (int i = 0; i < lat_c; i++) q.push_back(-1);
        if (ln >= 1 && ln <= 3) begin
            n    = 1 << (ln + 1);
            base = a & ~(n - 1);
            for (int j = 0; j < n; j++) begin
                if (!lin)    a2 = base | ((a ^ j) & (n - 1));
                else if (wr) a2 = base | ((a + j) & (n - 1));
                else         a2 = (a + j) & AMASK;
                q.push_back(a2);
            end
        end else begin
            armed = lin && wr && ((a & 15) >= 13);
            for (int j = 0; j < 64; j++) begin
                a2 = (a + j) & AMASK;
                if (armed && j > 0 && (a2 & 15) == 0) begin
                    for (int i = 0; i < lat_c; i++) q.push_back(-1);
                    armed = 0;
                end
                q.push_back(a2);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst || ce_n)  q.delete();
        else if (!stb_n)  build_q(int'(cfg_v), int'(addr_v));
        else if (q.size() > 0) void'(q.pop_front());
    end

    task automatic check_int(input string tag, input string what, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare_cycle();
        logic       ew, ev;
        logic [15:0] ed;
        if (q.size() == 0)  begin ew = 0; ev = 0; ed = 0; end
        else if (q[0] < 0)  begin ew = 1; ev = 0; ed = 0; end
        else begin
            ew = 0; ev = !oe_n; ed = ev ? word_of(q[0]) : 16'h0;
        end
        n_tests++;
        if (rd_wait !== ew || rd_valid !== ev || rd_data !== ed) begin
            n_fail++;
            $display("FAIL %s cycle: actual wait=%b valid=%b data=%h expected wait=%b valid=%b data=%h",
                     cur_tag, rd_wait, rd_valid, rd_data, ew, ev, ed);
        end
        if (rd_wait)  obs_wait++;
        if (rd_valid) obs.push_back(rd_data);
    endtask

    always @(posedge clk) begin
        #(CLK_P/4);
        if (checking) compare_cycle();
    end

    task automatic start_burst(input string tag, input logic [7:0] cv, input int a);
        @(negedge clk);
        cur_tag  = tag;
        obs.delete();
        obs_wait = 0;
        ce_n   = 1'b0;
        stb_n  = 1'b0;
        cfg_v  = cv;
        addr_v = AW'(a);
        @(negedge clk);
        stb_n  = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_burst(input string tag);
        ce_n = 1'b1;
        @(negedge clk);
        check_int(tag, "wait after ce high", int'(rd_wait), 0);
        check_int(tag, "valid after ce high", int'(rd_valid), 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; ce_n = 1'b1; oe_n = 1'b0; stb_n = 1'b1; cfg_v = '0; addr_v = '0;
        run(4);
        // R1 during reset
        check_int("R1", "wait in reset", int'(rd_wait), 0);
        check_int("R1", "valid in reset", int'(rd_valid), 0);
        check_int("R1", "data in reset", int'(rd_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check_int("R1", "wait after reset", int'(rd_wait), 0);
        check_int("R1", "valid after reset", int'(rd_valid), 0);
        checking = 1;

        // R3/R4/R5: continuous linear, L=3, address-space rollover, no wrap so no pause
        start_burst("R3/R4/R5", 8'hA0, 'h7FFFFC);
        run(19);
        check_int("R3", "initial wait cycles", obs_wait, 3);
        check_int("R5", "word after rollover", int'(obs[4]), int'(word_of(0)));
        check_int("R4", "first word", int'(obs[0]), int'(word_of('h7FFFFC)));
        end_burst("R11");

        // R9/R10: start offset 13, L=4, pause once, later crossings stream
        start_burst("R9/R10", 8'hB8, 'h20D);
        run(49);
        check_int("R9", "wait cycles with one pause", obs_wait, 8);
        check_int("R9", "word after pause", int'(obs[3]), int'(word_of('h210)));
        check_int("R10", "words delivered", obs.size(), 42);
        end_burst("R11");

        // R9: start offset 12 gives no pause
        start_burst("R9", 8'hB8, 'h30C);
        run(30);
        check_int("R9", "no pause from offset 12", obs_wait, 4);
        end_burst("R11");

        // R9: offset 15 with L=1 pauses right after the first word
        start_burst("R9", 8'h88, 'h1F);
        run(10);
        check_int("R9", "wait cycles offset 15", obs_wait, 2);
        check_int("R9", "second word", int'(obs[1]), int'(word_of('h20)));
        end_burst("R11");

        // R6/R7: fixed 4, linear wrap
        start_burst("R6/R7", 8'h99, 'h106);
        run(10);
        check_int("R6", "fixed 4 count", obs.size(), 4);
        check_int("R7", "wrapped word", int'(obs[2]), int'(word_of('h104)));
        end_burst("R11");

        // R7: fixed 8, linear no wrap
        start_burst("R6/R7", 8'h92, 'h10D);
        run(14);
        check_int("R6", "fixed 8 count", obs.size(), 8);
        check_int("R7", "no-wrap word", int'(obs[3]), int'(word_of('h110)));
        end_burst("R11");

        // R6/R7: fixed 16 wrap, L=5
        start_burst("R6/R7", 8'hCB, 'h4A3);
        run(25);
        check_int("R6", "fixed 16 count", obs.size(), 16);
        check_int("R7", "wrapped word 16", int'(obs[13]), int'(word_of('h4A0)));
        end_burst("R11");

        // R8: interleaved 8
        start_burst("R8", 8'h12, 'h55);
        run(12);
        check_int("R8", "interleaved count", obs.size(), 8);
        check_int("R8", "interleaved word 4", int'(obs[4]), int'(word_of('h51)));
        check_int("R8", "interleaved word 1", int'(obs[1]), int'(word_of('h54)));
        end_burst("R11");

        // R12: output enable high suppresses data, burst still advances
        start_burst("R12", 8'hA0, 'h600);
        run(5);
        oe_n = 1'b1;
        run(4);
        oe_n = 1'b0;
        run(4);
        check_int("R12", "visible words", obs.size(), 7);
        check_int("R12", "word after oe returns", int'(obs[3]), int'(word_of('h607)));
        end_burst("R11");

        // R2: restart mid-burst with a new address and configuration
        start_burst("R2", 8'hA0, 'h700);
        run(5);
        obs.delete();
        obs_wait = 0;
        stb_n  = 1'b0;
        addr_v = AW'('h7A5);
        cfg_v  = 8'h99;
        @(negedge clk);
        stb_n  = 1'b1;
        run(6);
        check_int("R2", "restart wait cycles", obs_wait, 2);
        check_int("R2", "restart count", obs.size(), 4);
        check_int("R2", "restart last word", int'(obs[3]), int'(word_of('h7A4)));

        // R11: ce high mid continuous burst
        start_burst("R11", 8'hA0, 'h800);
        run(6);
        end_burst("R11");

        run(2);
        checking = 0;
        summary();
    end

endmodule